// File: doc/BRIEF.md
# Indirect Command/Status Transfer Bridge

This block lets a host with a 64-bit register port reach a 32-bit-address downstream bus one transfer at a time. The host stores write data in a data register. It then writes one command word that holds the direction, the byte count (0 to 4) and the downstream address. The bridge runs the transfer on a request/acknowledge master port that has an error response. When the transfer ends, the bridge posts a status word. That word carries a done flag and, for reads, the returned bytes at a fixed position.

The host polls the status register. A status read returns the posted word and clears it, so each completion is seen once. Only one transfer runs at a time. While it runs, the status reads as zero and further commands are dropped. There is no burst, no caching and no decoding of downstream addresses.

Top module: `cmdstat_bridge`

## Requirements
- R1: Host address bits [4:3] select the register: 0 command, 1 reserved, 2 status, 3 data. A read returns its word one cycle after the request, with `host_rvalid` high for that one cycle. The command register and the reserved register both read as zero, and writes to the reserved register change nothing.
- R2: A data register write stores bits [63:32] of the written word. A data register read returns the stored value in bits [63:32], with bits [31:0] zero.
- R3: A command write decodes three fields: bit 48 set means read, bits [59:56] give the byte count, and bits [31:0] give the address. One cycle later the bridge raises `dn_req` with that address, count and direction, where `dn_we` is high for a write.
- R4: A command whose byte count is greater than 4 is rejected. No downstream request follows, and the status register keeps its previous value.
- R5: A write transfer drives the data register on `dn_wdata`, with the first byte in bits [31:24]. When it completes, with or without an error, the status is exactly 0x800, the done flag at bit 11.
- R6: A successful read posts status 0x800 together with the returned bytes in bits [57:26], first byte highest. Byte lanes at or beyond the byte count read as zero, and the downstream bus returns its first byte in `dn_rdata[31:24]`.
- R7: A read that ends with `dn_err` posts the done flag with bits [57:26] all ones.
- R8: A status read returns the current value and clears the register to zero. The status register is zero after reset and becomes zero when a command is accepted.
- R9: While a transfer is outstanding, the status reads zero and command writes are ignored. `dn_req` stays high with the address, size and direction held until the cycle in which `dn_ack` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | Host access is a write |
| host_addr | input | HOST_AW | Host byte address; bits [4:3] select the register |
| host_wdata | input | 64 | Host write word |
| host_rvalid | output | 1 | Read data valid |
| host_rdata | output | 64 | Read data |
| dn_req | output | 1 | Downstream request, held until acknowledged |
| dn_we | output | 1 | Downstream write direction |
| dn_addr | output | DN_AW | Downstream address |
| dn_size | output | 3 | Downstream byte count, 0 to 4 |
| dn_wdata | output | DN_DW | Downstream write data, first byte in the top lane |
| dn_ack | input | 1 | Downstream acknowledge |
| dn_err | input | 1 | Downstream error, valid with `dn_ack` |
| dn_rdata | input | DN_DW | Downstream read data, valid with `dn_ack` |

## Verification
Most internal faults in this block surface at the status port within a few cycles of the transfer's acknowledge.
- A wrong busy flag shows up in one of two ways. Either a second command reaches `dn_req` on the cycle after it is written, or a poll made during the transfer returns a non-zero word.
- A wrong field mask or shift corrupts the first status read after the acknowledge.
- A clear that fails is exposed by the very next poll, which returns the same word again.
- A rejected command that leaks through raises `dn_req` one cycle after the write, and the older status word is then lost.

// File: rtl/cmdstat_pkg.sv
package cmdstat_pkg;
  // Command word layout (LSB-0 positions)
  localparam int CMD_RD_BIT    = 48;
  localparam int CMD_CNT_LSB   = 56;
  localparam int CMD_CNT_W     = 4;
  // Status word layout
  localparam int STAT_DONE_BIT = 11;
  localparam int STAT_DATA_LSB = 26;
  localparam int STAT_DATA_W   = 32;
  // Data register placement within the 64-bit host word
  localparam int DATA_REG_LSB  = 32;
  localparam int HOST_DW       = 64;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_RSVD = 2'd1,
    SEL_STAT = 2'd2,
    SEL_DATA = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/cmdstat_rst_sync.sv
module cmdstat_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/cmdstat_decode.sv
module cmdstat_decode
  import cmdstat_pkg::*;
#(
  parameter int HOST_AW   = 5,
  parameter int MAX_BYTES = 4
) (
  input  logic                 host_req,
  input  logic                 host_we,
  input  logic [HOST_AW-1:0]   host_addr,
  input  logic [HOST_DW-1:0]   host_wdata,
  input  logic                 busy,
  output reg_sel_e             sel,
  output logic                 cmd_go,
  output logic                 cmd_rd,
  output logic [CMD_CNT_W-1:0] cmd_cnt,
  output logic                 data_we,
  output logic                 stat_rd,
  output logic                 rd_en
);
  logic cmd_wr;
  logic cnt_ok;
  logic unused_addr;

  assign unused_addr = ^{host_addr[2:0], host_addr[HOST_AW-1:3]};

  assign sel     = reg_sel_e'(host_addr[4:3]);
  assign cmd_rd  = host_wdata[CMD_RD_BIT];
  assign cmd_cnt = host_wdata[CMD_CNT_LSB +: CMD_CNT_W];
  assign cnt_ok  = (cmd_cnt <= CMD_CNT_W'(MAX_BYTES));
  assign cmd_wr  = host_req & host_we & (sel == SEL_CMD);
  assign cmd_go  = cmd_wr & cnt_ok & ~busy;
  assign data_we = host_req & host_we & (sel == SEL_DATA);
  assign stat_rd = host_req & ~host_we & (sel == SEL_STAT);
  assign rd_en   = host_req & ~host_we;
endmodule

// File: rtl/cmdstat_engine.sv
module cmdstat_engine #(
  parameter int DN_AW = 32,
  parameter int DN_DW = 32,
  localparam int MAX_BYTES = DN_DW / 8,
  localparam int SZ_W = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_go,
  input  logic             cmd_rd,
  input  logic [SZ_W-1:0]  cmd_size,
  input  logic [DN_AW-1:0] cmd_addr,
  input  logic [DN_DW-1:0] wr_data,
  output logic             busy,
  output logic             dn_req,
  output logic             dn_we,
  output logic [DN_AW-1:0] dn_addr,
  output logic [SZ_W-1:0]  dn_size,
  output logic [DN_DW-1:0] dn_wdata,
  input  logic             dn_ack,
  input  logic             dn_err,
  input  logic [DN_DW-1:0] dn_rdata,
  output logic             done,
  output logic             done_rd,
  output logic             done_err,
  output logic [DN_DW-1:0] rd_field
);
  logic             busy_q, busy_d;
  logic             we_q, we_d;
  logic [SZ_W-1:0]  size_q, size_d;
  logic [DN_AW-1:0] addr_q, addr_d;
  logic [DN_DW-1:0] wdata_q, wdata_d;
  logic             load;

  assign load = cmd_go & ~busy_q;

  always_comb begin
    busy_d  = busy_q;
    we_d    = we_q;
    size_d  = size_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    if (load) begin
      busy_d  = 1'b1;
      we_d    = ~cmd_rd;
      size_d  = cmd_size;
      addr_d  = cmd_addr;
      wdata_d = wr_data;
    end else if (busy_q && dn_ack) begin
      busy_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      size_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load) begin
      we_q    <= we_d;
      size_q  <= size_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end

  // Keep only the lanes covered by the byte count; lane 0 is the top byte.
  for (genvar b = 0; b < MAX_BYTES; b++) begin : g_lane
    localparam int HI = DN_DW - 1 - 8 * b;
    assign rd_field[HI -: 8] = (size_q > SZ_W'(b)) ? dn_rdata[HI -: 8] : 8'h00;
  end

  assign busy     = busy_q;
  assign dn_req   = busy_q;
  assign dn_we    = we_q;
  assign dn_addr  = addr_q;
  assign dn_size  = size_q;
  assign dn_wdata = wdata_q;
  assign done     = busy_q & dn_ack;
  assign done_rd  = ~we_q;
  assign done_err = dn_err;
endmodule

// File: rtl/cmdstat_status.sv
module cmdstat_status
  import cmdstat_pkg::*;
#(
  parameter int DN_DW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               clr,
  input  logic               done,
  input  logic               done_rd,
  input  logic               done_err,
  input  logic [DN_DW-1:0]   rd_field,
  output logic [HOST_DW-1:0] stat
);
  logic [HOST_DW-1:0]     stat_q, stat_d, posted;
  logic [STAT_DATA_W-1:0] field;
  logic                   stat_en;

  always_comb begin
    field = done_err ? '1 : STAT_DATA_W'(rd_field);
    posted = '0;
    posted[STAT_DONE_BIT] = 1'b1;
    if (done_rd) posted[STAT_DATA_LSB +: STAT_DATA_W] = field;
  end

  // A completion wins over a clear in the same cycle.
  always_comb begin
    stat_en = done | start | clr;
    if (done) stat_d = posted;
    else      stat_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  assign stat = stat_q;
endmodule

// File: rtl/cmdstat_bridge.sv
module cmdstat_bridge
  import cmdstat_pkg::*;
#(
  parameter int HOST_AW = 5,
  parameter int DN_AW   = 32,
  parameter int DN_DW   = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              host_req,
  input  logic                              host_we,
  input  logic [HOST_AW-1:0]                host_addr,
  input  logic [63:0]                       host_wdata,
  output logic                              host_rvalid,
  output logic [63:0]                       host_rdata,
  output logic                              dn_req,
  output logic                              dn_we,
  output logic [DN_AW-1:0]                  dn_addr,
  output logic [$clog2(DN_DW/8+1)-1:0]      dn_size,
  output logic [DN_DW-1:0]                  dn_wdata,
  input  logic                              dn_ack,
  input  logic                              dn_err,
  input  logic [DN_DW-1:0]                  dn_rdata
);
  localparam int MAX_BYTES = DN_DW / 8;
  localparam int SZ_W      = $clog2(MAX_BYTES + 1);
  localparam int DREG_W    = HOST_DW - DATA_REG_LSB;

  logic                 rst_i_n;
  reg_sel_e             sel;
  logic                 cmd_go, cmd_rd, data_we, stat_rd, rd_en, busy;
  logic [CMD_CNT_W-1:0] cmd_cnt;
  logic                 done, done_rd, done_err;
  logic [DN_DW-1:0]     rd_field;
  logic [HOST_DW-1:0]   stat;
  logic [DREG_W-1:0]    data_q;
  logic [HOST_DW-1:0]   rdata_q, rdata_d;
  logic                 rvalid_q;

  cmdstat_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  cmdstat_decode #(.HOST_AW(HOST_AW), .MAX_BYTES(MAX_BYTES)) u_dec (
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .busy(busy), .sel(sel), .cmd_go(cmd_go),
    .cmd_rd(cmd_rd), .cmd_cnt(cmd_cnt), .data_we(data_we),
    .stat_rd(stat_rd), .rd_en(rd_en)
  );

  cmdstat_engine #(.DN_AW(DN_AW), .DN_DW(DN_DW)) u_eng (
    .clk(clk), .rst_n(rst_i_n), .cmd_go(cmd_go), .cmd_rd(cmd_rd),
    .cmd_size(cmd_cnt[SZ_W-1:0]), .cmd_addr(host_wdata[DN_AW-1:0]),
    .wr_data(data_q[DREG_W-1 -: DN_DW]), .busy(busy),
    .dn_req(dn_req), .dn_we(dn_we), .dn_addr(dn_addr), .dn_size(dn_size),
    .dn_wdata(dn_wdata), .dn_ack(dn_ack), .dn_err(dn_err),
    .dn_rdata(dn_rdata), .done(done), .done_rd(done_rd),
    .done_err(done_err), .rd_field(rd_field)
  );

  cmdstat_status #(.DN_DW(DN_DW)) u_stat (
    .clk(clk), .rst_n(rst_i_n), .start(cmd_go), .clr(stat_rd),
    .done(done), .done_rd(done_rd), .done_err(done_err),
    .rd_field(rd_field), .stat(stat)
  );

  // Data register: upper half of the host word only.
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)     data_q <= '0;
    else if (data_we) data_q <= host_wdata[HOST_DW-1:DATA_REG_LSB];
  end

  always_comb begin
    unique case (sel)
      SEL_STAT: rdata_d = stat;
      SEL_DATA: rdata_d = {data_q, {DATA_REG_LSB{1'b0}}};
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) rvalid_q <= 1'b0;
    else          rvalid_q <= rd_en;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)   rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  assign host_rvalid = rvalid_q;
  assign host_rdata  = rdata_q;
endmodule

// File: rtl/cmdstat_checker.sv
module cmdstat_checker #(
  parameter int DN_AW = 32,
  parameter int SZ_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_req,
  input logic             host_we,
  input logic [1:0]       sel,
  input logic [3:0]       cmd_cnt,
  input logic             host_rvalid,
  input logic [63:0]      host_rdata,
  input logic             dn_req,
  input logic             dn_we,
  input logic [DN_AW-1:0] dn_addr,
  input logic [SZ_W-1:0]  dn_size,
  input logic             dn_ack
);
  // R9: request and its fields held until acknowledged
  assert_hold_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req && !dn_ack |=> dn_req && $stable(dn_addr) && $stable(dn_size) && $stable(dn_we));

  // R3: a request starts only after a valid command write
  assert_start_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_req) |-> $past(host_req && host_we && sel == 2'd0 && cmd_cnt <= 4'd4));

  // R3: size on the bus never exceeds four bytes
  assert_size_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req |-> dn_size <= SZ_W'(4));

  // R4: oversize command issues nothing
  assert_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
    host_req && host_we && sel == 2'd0 && cmd_cnt > 4'd4 && !dn_req |=> !dn_req);

  // R1: reserved register reads zero
  assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    host_req && !host_we && sel == 2'd1 |=> host_rvalid && host_rdata == 64'h0);

  // R2: data register low half reads zero
  assert_data_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    host_req && !host_we && sel == 2'd3 |=> host_rvalid && host_rdata[31:0] == 32'h0);

  // R9: status polled during a transfer reads zero
  assert_busy_stat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    host_req && !host_we && sel == 2'd2 && dn_req |=> host_rdata == 64'h0);
endmodule

bind cmdstat_bridge cmdstat_checker #(.DN_AW(DN_AW), .SZ_W($clog2(DN_DW/8+1))) u_chk (
  .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
  .sel(host_addr[4:3]), .cmd_cnt(host_wdata[59:56]),
  .host_rvalid(host_rvalid), .host_rdata(host_rdata),
  .dn_req(dn_req), .dn_we(dn_we), .dn_addr(dn_addr),
  .dn_size(dn_size), .dn_ack(dn_ack)
);

// File: tb/tb_cmdstat_bridge.sv
`timescale 1ns/1ps
module tb_cmdstat_bridge;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_req, host_we;
  logic [4:0]  host_addr;
  logic [63:0] host_wdata;
  logic        host_rvalid;
  logic [63:0] host_rdata;
  logic        dn_req, dn_we;
  logic [31:0] dn_addr, dn_wdata, dn_rdata;
  logic [2:0]  dn_size;
  logic        dn_ack, dn_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic [63:0] exp_q[$];
  string       tag_q[$];

  int          resp_lat  = 0;
  logic        resp_err  = 1'b0;
  logic [31:0] resp_data = 32'h0;
  int          n_xfers   = 0;
  logic [31:0] cap_addr, cap_wdata;
  logic [2:0]  cap_size;
  logic        cap_we;

  always #4 clk = ~clk;

  cmdstat_bridge dut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rvalid(host_rvalid), .host_rdata(host_rdata),
    .dn_req(dn_req), .dn_we(dn_we), .dn_addr(dn_addr), .dn_size(dn_size),
    .dn_wdata(dn_wdata), .dn_ack(dn_ack), .dn_err(dn_err), .dn_rdata(dn_rdata)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] rd_stat(input logic [31:0] field);
    return 64'h800 | ({32'h0, field} << 26);
  endfunction

  function automatic logic [63:0] cmd_word(input logic rd, input logic [3:0] cnt,
                                            input logic [31:0] addr);
    logic [63:0] w;
    w = '0;
    w[48] = rd;
    w[59:56] = cnt;
    w[31:0] = addr;
    return w;
  endfunction

  task automatic host_access(input logic we, input logic [1:0] sel, input logic [63:0] wd);
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = {sel, 3'b000}; host_wdata = wd;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
  endtask

  // Driver side of the scoreboard: push the expected word, then issue the read.
  task automatic host_read(input logic [1:0] sel, input logic [63:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    host_access(1'b0, sel, 64'h0);
  endtask

  task automatic run_cmd(input logic rd, input logic [3:0] cnt, input logic [31:0] addr);
    host_access(1'b1, 2'd0, cmd_word(rd, cnt, addr));
    repeat (resp_lat + 4) @(negedge clk);
  endtask

  // Monitor side of the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (host_rvalid) begin
        if (exp_q.size() == 0) begin
          n_checks++; n_fail++;
          $display("FAIL R1: unexpected read data actual %h expected none", host_rdata);
        end else begin
          check(tag_q.pop_front(), host_rdata, exp_q.pop_front());
        end
      end
    end
  end

  // Downstream responder
  initial begin
    int wait_cnt;
    wait_cnt = 0;
    dn_ack = 1'b0; dn_err = 1'b0; dn_rdata = 32'h0;
    forever begin
      @(negedge clk);
      if (dn_ack) begin
        dn_ack = 1'b0; dn_err = 1'b0; dn_rdata = 32'h0;
      end else if (dn_req) begin
        if (wait_cnt >= resp_lat) begin
          dn_ack = 1'b1; dn_err = resp_err; dn_rdata = resp_data;
          cap_addr = dn_addr; cap_size = dn_size; cap_we = dn_we; cap_wdata = dn_wdata;
          n_xfers++;
          wait_cnt = 0;
        end else begin
          wait_cnt++;
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int base;
    host_req = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8: reset state
    check("R8 reset dn_req", {63'h0, dn_req}, 64'h0);
    host_read(2'd2, 64'h0, "R8 status after reset");

    // R2: data register
    host_access(1'b1, 2'd3, 64'hA1B2C3D4_55667788);
    host_read(2'd3, 64'hA1B2C3D4_00000000, "R2 data readback");

    // R1: reserved and command registers
    host_access(1'b1, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    host_read(2'd1, 64'h0, "R1 reserved reads zero");
    host_read(2'd3, 64'hA1B2C3D4_00000000, "R1 reserved write left data intact");
    host_read(2'd0, 64'h0, "R1 command reads zero");

    // R3/R5: write transfer
    resp_lat = 0; resp_err = 1'b0;
    base = n_xfers;
    run_cmd(1'b0, 4'd4, 32'h1234_5678);
    check("R3 one transfer", 64'(n_xfers - base), 64'd1);
    check("R3 address", {32'h0, cap_addr}, 64'h1234_5678);
    check("R3 size", {61'h0, cap_size}, 64'd4);
    check("R3 direction write", {63'h0, cap_we}, 64'd1);
    check("R5 write data", {32'h0, cap_wdata}, 64'hA1B2C3D4);
    host_read(2'd2, 64'h800, "R5 write status");
    host_read(2'd2, 64'h0, "R8 status cleared by read");

    // R6: successful reads
    resp_data = 32'h1122_3344;
    run_cmd(1'b1, 4'd4, 32'hD001_0060);
    check("R3 direction read", {63'h0, cap_we}, 64'd0);
    host_read(2'd2, rd_stat(32'h1122_3344), "R6 read 4 bytes");
    resp_data = 32'hAABB_CCDD;
    run_cmd(1'b1, 4'd2, 32'h0000_0010);
    check("R3 size 2", {61'h0, cap_size}, 64'd2);
    host_read(2'd2, rd_stat(32'hAABB_0000), "R6 read 2 bytes masked");

    // R7: failed read
    resp_err = 1'b1;
    run_cmd(1'b1, 4'd1, 32'h0000_0020);
    host_read(2'd2, rd_stat(32'hFFFF_FFFF), "R7 read error");
    resp_err = 1'b0;

    // R4: oversize command rejected, status preserved
    resp_data = 32'h5A00_0000;
    run_cmd(1'b1, 4'd1, 32'h0000_0030);
    base = n_xfers;
    run_cmd(1'b1, 4'd5, 32'h0000_0040);
    check("R4 no transfer", 64'(n_xfers - base), 64'd0);
    host_read(2'd2, rd_stat(32'h5A00_0000), "R4 status kept");

    // R9: busy behaviour
    resp_lat = 6; resp_data = 32'hCAFE_F00D;
    base = n_xfers;
    host_access(1'b1, 2'd0, cmd_word(1'b1, 4'd4, 32'h0000_0100));
    host_read(2'd2, 64'h0, "R9 status zero while busy");
    host_access(1'b1, 2'd0, cmd_word(1'b0, 4'd4, 32'h0000_0200));
    repeat (12) @(negedge clk);
    check("R9 second command ignored", 64'(n_xfers - base), 64'd1);
    check("R9 first address used", {32'h0, cap_addr}, 64'h0000_0100);
    host_read(2'd2, rd_stat(32'hCAFE_F00D), "R9 status after busy");

    // R5: write with error still reports done only
    resp_lat = 1; resp_err = 1'b1;
    run_cmd(1'b0, 4'd3, 32'h0000_0300);
    host_read(2'd2, 64'h800, "R5 write error status");
    resp_err = 1'b0;

    repeat (4) @(negedge clk);
    check("scoreboard drained", 64'(exp_q.size()), 64'd0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule